// File: doc/BRIEF.md
# Hotswap Switch Sequencing Controller

This block decides how the input hotswap switch of a powered Ethernet device is driven. It runs a four-state machine: switch off, inrush current limiting, fully on, and low current-limit overload. A two-bit mode code goes to the analog gate loop. The controller reads an undervoltage-lockout flag, a flag that marks a Type 1 power grant, and two comparator flags that watch the voltage across the switch. One flag means the input capacitor is charged (below about 380 mV). The other means an overload (above about 3.5 V).

Two dwell rules are handled by counters:
- A minimum stay in inrush, and in overload, before the switch may turn fully on. The default is 80 ms of clock cycles.
- A persistence qualification on the overload flag. The default is 140 µs of clock cycles.

A select output steers conduction between the internal FET and an external parallel FET. It is driven from two average-current flags with hysteresis, so that it does not chatter.

Top module: `hsw_ctrl`

## Requirements
- R1: During reset and directly after it, `mode` is 2'b00 (off) and `ext_sel` is 0.
- R2: When `uvlo` is sampled high in any state, `mode` is 2'b00 in the next cycle. It stays 2'b00 as long as `uvlo` remains high.
- R3: In off with `uvlo` sampled low, `mode` becomes 2'b01 (inrush) in the next cycle.
- R4: In inrush, when `uvlo` is low and both `type1` and `v_low` are high, `mode` becomes 2'b10 (on) in the next cycle, whatever the time already spent in inrush.
- R5: In inrush with `type1` low, let cycle 0 be the first cycle that shows 2'b01. If `v_low` is high from cycle j0 onward, `mode` shows 2'b10 from cycle max(DWELL_CYC-1, j0)+1.
- R6: In on, `mode` becomes 2'b11 (overload) one cycle after `v_high` has been high for QUAL_CYC consecutive cycles. Any shorter run has no effect, and a single low cycle restarts the count.
- R7: In overload, `mode` returns to 2'b10 by the same timing as R5, counted from the first 2'b11 cycle. `type1` does not shorten this wait, and `v_high` has no effect while in overload.
- R8: While `mode` is 2'b10, `ext_sel` is set one cycle after `i_hi` is sampled high. It is cleared one cycle after `i_lo` is sampled high. It holds its value when neither flag is high.
- R9: `ext_sel` is 0 in every cycle in which `mode` is not 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo | input | 1 | Undervoltage lockout active |
| type1 | input | 1 | Power grant is Type 1 (no inrush dwell) |
| v_low | input | 1 | Switch voltage below the charge-complete level |
| v_high | input | 1 | Switch voltage above the overload level |
| i_hi | input | 1 | Average input current above the upper crossover |
| i_lo | input | 1 | Average input current below the lower crossover |
| mode | output | 2 | Gate loop mode: 00 off, 01 inrush, 10 on, 11 overload |
| ext_sel | output | 1 | 1 = external FET carries the current |

## Verification
Every mode change is due exactly one cycle after the input sample that triggers it. The dwell rules push that sample to cycle DWELL_CYC-1 of the state, and the overload rule pushes it to the QUAL_CYC-th consecutive high cycle of `v_high`. The select output changes in the same cycle as the mode it depends on. The bench drives inputs and compares outputs on the falling clock edge, so each comparison sees the result of exactly one rising edge. It sweeps the arrival cycle of `v_low` across the whole dwell window, and the length of the `v_high` run across the qualification limit. It compares each cycle against an expected mode computed from max(DWELL_CYC-1, j0)+1 and from QUAL_CYC.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic [1:0] {
    HS_OFF    = 2'b00,
    HS_INRUSH = 2'b01,
    HS_ON     = 2'b10,
    HS_OVL    = 2'b11
  } hs_state_e;
endpackage

// File: rtl/hsw_dwell.sv
// Counts cycles spent in the current state; done once LIMIT cycles have
// elapsed including the present one. Restart clears on state entry.
module hsw_dwell #(
  parameter int LIMIT = 80000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic done
);
  localparam int CW = $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = restart | (cnt_q != LAST);
    cnt_d  = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == LAST);
endmodule

// File: rtl/hsw_persist.sv
// Fires when level has been high for LIMIT consecutive armed cycles.
module hsw_persist #(
  parameter int LIMIT = 140
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic level,
  output logic fire
);
  localparam int CW = $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] run_q, run_d;
  logic          run_en;
  logic          hold;

  always_comb begin
    hold   = arm & level;
    run_en = !hold | (run_q != LAST);
    run_d  = hold ? run_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  assign fire = hold & (run_q == LAST);
endmodule

// File: rtl/hsw_fet_sel.sv
// Hysteretic internal/external FET steering, valid only while fully on.
module hsw_fet_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic keep,
  input  logic i_hi,
  input  logic i_lo,
  output logic ext_sel
);
  logic sel_d;

  always_comb begin
    if (!keep)     sel_d = 1'b0;
    else if (i_hi) sel_d = 1'b1;
    else if (i_lo) sel_d = 1'b0;
    else           sel_d = ext_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_sel <= 1'b0;
    else        ext_sel <= sel_d;
  end
endmodule

// File: rtl/hsw_ctrl.sv
module hsw_ctrl
  import hsw_pkg::*;
#(
  parameter int DWELL_CYC = 80000,
  parameter int QUAL_CYC  = 140
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uvlo,
  input  logic       type1,
  input  logic       v_low,
  input  logic       v_high,
  input  logic       i_hi,
  input  logic       i_lo,
  output logic [1:0] mode,
  output logic       ext_sel
);
  hs_state_e st_q, st_d;
  logic      dwell_done;
  logic      ovl_fire;
  logic      st_change;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_OFF:    st_d = HS_INRUSH;
      HS_INRUSH: if (v_low && (type1 || dwell_done)) st_d = HS_ON;
      HS_ON:     if (ovl_fire) st_d = HS_OVL;
      HS_OVL:    if (v_low && dwell_done) st_d = HS_ON;
      default:   st_d = HS_OFF;
    endcase
    if (uvlo) st_d = HS_OFF;
    st_change = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= HS_OFF;
    else        st_q <= st_d;
  end

  hsw_dwell #(.LIMIT(DWELL_CYC)) dwell_i (
    .clk(clk), .rst_n(rst_n), .restart(st_change), .done(dwell_done)
  );

  hsw_persist #(.LIMIT(QUAL_CYC)) persist_i (
    .clk(clk), .rst_n(rst_n), .arm(st_q == HS_ON), .level(v_high), .fire(ovl_fire)
  );

  hsw_fet_sel fet_i (
    .clk(clk), .rst_n(rst_n), .keep(st_d == HS_ON),
    .i_hi(i_hi), .i_lo(i_lo), .ext_sel(ext_sel)
  );

  assign mode = st_q;
endmodule

// File: rtl/hsw_ctrl_chk.sv
module hsw_ctrl_chk #(
  parameter int DWELL_CYC = 80000,
  parameter int QUAL_CYC  = 140
) (
  input logic       clk,
  input logic       rst_n,
  input logic       uvlo,
  input logic       type1,
  input logic       v_low,
  input logic       v_high,
  input logic       i_hi,
  input logic [1:0] mode,
  input logic       ext_sel
);
  localparam int DW = $clog2(DWELL_CYC + 1);
  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam logic [DW-1:0] DSAT = DW'(DWELL_CYC);
  localparam logic [DW-1:0] DREQ = DW'(DWELL_CYC - 1);
  localparam logic [QW-1:0] QSAT = QW'(QUAL_CYC);
  localparam logic [QW-1:0] QREQ = QW'(QUAL_CYC - 1);

  logic [1:0]    ck_prev;
  logic [DW-1:0] ck_dw;
  logic [QW-1:0] ck_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_prev <= 2'b00;
      ck_dw   <= '0;
      ck_run  <= '0;
    end else begin
      ck_prev <= mode;
      if (mode != ck_prev)  ck_dw <= DW'(1);
      else if (ck_dw != DSAT) ck_dw <= ck_dw + 1'b1;
      if (!v_high)          ck_run <= '0;
      else if (ck_run != QSAT) ck_run <= ck_run + 1'b1;
    end
  end

  // R2
  uvlo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> mode == 2'b00);
  // R3
  off_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !uvlo) |=> mode == 2'b01);
  // R4
  type1_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && !uvlo && type1 && v_low) |=> mode == 2'b10);
  // R5
  inrush_dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && $past(mode) == 2'b01 && !$past(type1))
      |-> ($past(ck_prev) == 2'b01 && $past(ck_dw) >= DREQ));
  // R6
  ovl_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && $past(mode) == 2'b10)
      |-> ($past(v_high) && $past(ck_run) >= QREQ));
  // R7
  ovl_dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && $past(mode) == 2'b11)
      |-> ($past(ck_prev) == 2'b11 && $past(ck_dw) >= DREQ && $past(v_low)));
  // R8
  sel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_sel) |-> $past(i_hi));
  // R9
  sel_on_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sel |-> mode == 2'b10);
endmodule

bind hsw_ctrl hsw_ctrl_chk #(.DWELL_CYC(DWELL_CYC), .QUAL_CYC(QUAL_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .type1(type1), .v_low(v_low),
  .v_high(v_high), .i_hi(i_hi), .mode(mode), .ext_sel(ext_sel)
);

// File: tb/hsw_ctrl_test.sv
`timescale 1ns/1ps
module hsw_ctrl_test;
  localparam int D = 16;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n, uvlo, type1, v_low, v_high, i_hi, i_lo;
  logic [1:0] mode;
  logic ext_sel;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  hsw_ctrl #(.DWELL_CYC(D), .QUAL_CYC(Q)) uut (
    .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .type1(type1), .v_low(v_low),
    .v_high(v_high), .i_hi(i_hi), .i_lo(i_lo), .mode(mode), .ext_sel(ext_sel)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic to_inrush();
    uvlo = 1'b1; v_low = 1'b0; v_high = 1'b0;
    tick();
    chk("R2 lockout to off", mode, 2'b00);
    uvlo = 1'b0;
    tick();
    chk("R3 off to inrush", mode, 2'b01);
  endtask

  task automatic to_on();
    type1 = 1'b1;
    to_inrush();
    v_low = 1'b1;
    tick();
    chk("R4 type1 immediate on", mode, 2'b10);
    v_low = 1'b0; type1 = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; uvlo = 1'b1; type1 = 1'b0; v_low = 1'b0;
    v_high = 1'b0; i_hi = 1'b0; i_lo = 1'b0;
    repeat (3) tick();
    chk("R1 reset mode", mode, 2'b00);
    chk("R1 reset sel", {1'b0, ext_sel}, 2'b00);
    rst_n = 1'b1;
    tick();
    chk("R1 after reset mode", mode, 2'b00);
    repeat (4) begin
      tick();
      chk("R2 held lockout", mode, 2'b00);
    end

    // R5: v_low arrival swept across the inrush dwell window
    for (int j0 = 0; j0 <= D + 2; j0++) begin
      type1 = 1'b0;
      to_inrush();
      begin
        int t;
        t = (j0 > D - 1) ? j0 : D - 1;
        for (int j = 0; j <= t + 2; j++) begin
          chk("R5 inrush dwell", mode, (j >= t + 1) ? 2'b10 : 2'b01);
          v_low = (j >= j0);
          tick();
        end
      end
      v_low = 1'b0;
    end

    // R6: overload qualification run length sweep
    for (int L = 1; L <= Q + 1; L++) begin
      to_on();
      for (int i = 0; i <= Q + 2; i++) begin
        chk("R6 overload qual", mode, (L >= Q && i >= Q) ? 2'b11 : 2'b10);
        v_high = (i < L);
        tick();
      end
      v_high = 1'b0;
    end

    // R6: an interrupted run restarts the count
    to_on();
    for (int i = 0; i <= 2 * Q; i++) begin
      chk("R6 interrupted run", mode, 2'b10);
      v_high = (i != Q - 1) && (i < 2 * Q - 1);
      tick();
    end
    v_high = 1'b0;

    // R7: recovery dwell, type1 high and v_high held
    for (int j0 = 0; j0 <= D + 1; j0++) begin
      to_on();
      for (int i = 0; i < Q; i++) begin
        v_high = 1'b1;
        tick();
      end
      chk("R7 entered overload", mode, 2'b11);
      type1 = 1'b1;
      begin
        int t;
        t = (j0 > D - 1) ? j0 : D - 1;
        for (int j = 0; j <= t + 2; j++) begin
          chk("R7 overload dwell", mode, (j >= t + 1) ? 2'b10 : 2'b11);
          v_low = (j >= j0);
          tick();
        end
      end
      type1 = 1'b0; v_low = 1'b0; v_high = 1'b0;
    end

    // R2: lockout from overload
    to_on();
    for (int i = 0; i < Q; i++) begin
      v_high = 1'b1;
      tick();
    end
    chk("R6 overload before lockout", mode, 2'b11);
    uvlo = 1'b1;
    tick();
    chk("R2 overload to off", mode, 2'b00);
    tick();
    chk("R2 stays off", mode, 2'b00);
    v_high = 1'b0;

    // R8: hysteretic select while on
    to_on();
    chk("R8 select starts internal", {1'b0, ext_sel}, 2'b00);
    i_hi = 1'b1; tick();
    chk("R8 set by high current", {1'b0, ext_sel}, 2'b01);
    i_hi = 1'b0; tick();
    chk("R8 hold between flags", {1'b0, ext_sel}, 2'b01);
    tick();
    chk("R8 hold again", {1'b0, ext_sel}, 2'b01);
    i_lo = 1'b1; tick();
    chk("R8 cleared by low current", {1'b0, ext_sel}, 2'b00);
    i_lo = 1'b0; tick();
    chk("R8 hold cleared", {1'b0, ext_sel}, 2'b00);
    i_hi = 1'b1; tick();
    chk("R8 set again", {1'b0, ext_sel}, 2'b01);
    uvlo = 1'b1; tick();
    chk("R9 cleared leaving on", {1'b0, ext_sel}, 2'b00);
    chk("R9 mode off", mode, 2'b00);

    // R9: high current in inrush keeps internal FET
    type1 = 1'b0;
    to_inrush();
    tick();
    chk("R9 inrush ignores high current", {1'b0, ext_sel}, 2'b00);
    i_hi = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule